// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Unit

This block holds two small pending vectors with one bit per processor, for up to four processors. One vector records interprocessor interrupts. The other records interval-timer interrupts. Each pending bit drives one interrupt line. A processor raises or retires interrupts through a register port. A timer tick input marks a timer interrupt as pending for every processor in the system.

The register port has four register selects.

- **Control register (select 0).** One write to it can post interprocessor interrupts, retire interprocessor interrupts and retire timer interrupts together, because each action has its own bit field. A read of it returns both vectors and the identity of the processor that issued the read.
- **Three dedicated registers (selects 1 to 3).** Each one exposes a single action on the low four bits of the data word.

An error pulse marks a write that names nothing the block acts on. A warning pulse marks a request for an interprocessor interrupt that is already pending.

Top module: `ipt_unit`

## Requirements
- R1: After reset both pending vectors are zero, every interrupt output is low, and `rd_valid`, `err_pulse` and `warn_pulse` are low.
- R2: A control write (select 0) with a one in write bit 12+i sets the interprocessor pending bit of processor i.
- R3: A control write with a one in bit 8+i clears the interprocessor pending bit of processor i. A one in bit 4+i clears the timer pending bit of processor i. Clearing a bit that is not pending leaves both vectors unchanged.
- R4: When one control write both requests and clears the interprocessor interrupt of the same processor, the request is applied first and the clear second, so the bit ends up clear.
- R5: A one-cycle `tick` sets the timer pending bit of every present processor. If a timer clear for a processor arrives in the same cycle as a tick, the tick wins and the bit stays set.
- R6: Bits for processors at index NPROC or above never become pending and are not driven.
- R7: A control write that has bits 15:4 all zero and bit 28 zero pulses `err_pulse` for one cycle and changes no state. A control write whose only set bit is bit 28 is accepted silently and changes no state.
- R8: A request for a processor whose interprocessor bit is already pending leaves that bit set and pulses `warn_pulse` for one cycle. A request that finds no such bit leaves `warn_pulse` low.
- R9: A control read returns the interprocessor vector in bits 11:8, the timer vector in bits 7:4, the requester's 2-bit `req_cpu` in bits 1:0 and zero elsewhere. The data appears with `rd_valid` in the cycle after the request.
- R10: A read of select 1 returns the interprocessor vector in bits 3:0. A read of select 2 returns the timer vector in bits 3:0. Writing either select clears the vector bits named by data bits 3:0. A read of select 3 returns zero.
- R11: A write to select 3 sets the interprocessor pending bits named by data bits 3:0, with the same warning rule as R8.
- R12: A write to select 1, 2 or 3 whose data bits 3:0 are all zero pulses `err_pulse` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 control, 1 interprocessor vector, 2 timer vector, 3 interprocessor request |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | Identity of the requesting processor |
| tick | input | 1 | Interval-timer tick |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| ipi_irq | output | NPROC | Interprocessor interrupt per processor |
| tmr_irq | output | NPROC | Timer interrupt per processor |
| err_pulse | output | 1 | Unsupported write seen |
| warn_pulse | output | 1 | Request hit an already-pending interrupt |

## Verification
Every result is registered once. State changes, error and warning pulses, and read data all appear one clock edge after the request or tick that causes them.

The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Each outcome is therefore checked in the single cycle where it is due. The pulse checks also confirm that `err_pulse` and `warn_pulse` are low in the cycles where they must not fire.

The bench uses three processors. It sweeps every combination of starting interprocessor state, request field and clear field, so the absent fourth processor is covered by masking in every case.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   localparam int MAX_PROC   = 4;
   localparam int REQ_LSB    = 12;
   localparam int IPICLR_LSB = 8;
   localparam int TMRCLR_LSB = 4;
   localparam int NXM_BIT    = 28;
   localparam int RD_IPI_LSB = 8;
   localparam int RD_TMR_LSB = 4;

   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_IPI_VEC = 2'd1,
      SEL_TMR_VEC = 2'd2,
      SEL_IPI_SET = 2'd3
   } ipt_sel_e;

   typedef logic [MAX_PROC-1:0] proc_vec_t;
endpackage

// File: rtl/ipt_pend_vec.sv
module ipt_pend_vec
   import ipt_pkg::*;
#(
   parameter int NPROC      = 4,
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  proc_vec_t set_i,
   input  proc_vec_t clr_i,
   output proc_vec_t pend_o,
   output logic      dup_o
);
   localparam proc_vec_t PRESENT = proc_vec_t'((1 << NPROC) - 1);

   proc_vec_t pend_q;
   proc_vec_t pend_d;
   proc_vec_t set_m;

   assign set_m = set_i & PRESENT;

   generate
      if (CLEAR_WINS) begin : g_clear_last
         always_comb pend_d = ((pend_q | set_m) & ~clr_i) & PRESENT;
      end else begin : g_set_last
         always_comb pend_d = ((pend_q & ~clr_i) | set_m) & PRESENT;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;
   assign dup_o  = |(set_m & pend_q);

   AST_ABSENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~PRESENT) == '0); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(pend_q)); // R3

   generate
      if (CLEAR_WINS) begin : g_chk_clear
         AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0)); // R4
      end else begin : g_chk_set
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_m != '0) |=> ((pend_q & $past(set_m)) == $past(set_m))); // R5
      end
   endgenerate
endmodule

// File: rtl/ipt_wr_decode.sv
module ipt_wr_decode
   import ipt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              wr_en,
   input  ipt_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output proc_vec_t         ipi_set,
   output proc_vec_t         ipi_clr,
   output proc_vec_t         tmr_clr,
   output logic              bad_wr
);
   proc_vec_t f_req, f_ipiclr, f_tmrclr, f_low;
   logic      nxm;

   assign f_req    = wdata[REQ_LSB    +: MAX_PROC];
   assign f_ipiclr = wdata[IPICLR_LSB +: MAX_PROC];
   assign f_tmrclr = wdata[TMRCLR_LSB +: MAX_PROC];
   assign f_low    = wdata[0 +: MAX_PROC];
   assign nxm      = wdata[NXM_BIT];

   always_comb begin
      ipi_set = '0;
      ipi_clr = '0;
      tmr_clr = '0;
      bad_wr  = 1'b0;
      if (wr_en) begin
         unique case (sel)
            SEL_CTRL: begin
               ipi_set = f_req;
               ipi_clr = f_ipiclr;
               tmr_clr = f_tmrclr;
               bad_wr  = (f_req == '0) && (f_ipiclr == '0) &&
                         (f_tmrclr == '0) && !nxm;
            end
            SEL_IPI_VEC: begin
               ipi_clr = f_low;
               bad_wr  = (f_low == '0);
            end
            SEL_TMR_VEC: begin
               tmr_clr = f_low;
               bad_wr  = (f_low == '0);
            end
            SEL_IPI_SET: begin
               ipi_set = f_low;
               bad_wr  = (f_low == '0);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ipt_rd_mux.sv
module ipt_rd_mux
   import ipt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  ipt_sel_e          sel,
   input  proc_vec_t         ipi,
   input  proc_vec_t         tmr,
   input  logic [1:0]        cpu_id,
   output logic [DATA_W-1:0] data
);
   always_comb begin
      data = '0;
      unique case (sel)
         SEL_CTRL: begin
            data[RD_IPI_LSB +: MAX_PROC] = ipi;
            data[RD_TMR_LSB +: MAX_PROC] = tmr;
            data[1:0]                    = cpu_id;
         end
         SEL_IPI_VEC: data[0 +: MAX_PROC] = ipi;
         SEL_TMR_VEC: data[0 +: MAX_PROC] = tmr;
         default:     data = '0;
      endcase
   end
endmodule

// File: rtl/ipt_unit.sv
module ipt_unit
   import ipt_pkg::*;
#(
   parameter int NPROC  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_sel,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_cpu,
   input  logic              tick,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [NPROC-1:0]  ipi_irq,
   output logic [NPROC-1:0]  tmr_irq,
   output logic              err_pulse,
   output logic              warn_pulse
);
   generate
      if (NPROC < 1 || NPROC > MAX_PROC) begin : g_bad_nproc
         $error("ipt_unit: NPROC must be between 1 and 4");
      end
      if (DATA_W <= NXM_BIT) begin : g_bad_width
         $error("ipt_unit: DATA_W must exceed the ignored-flag bit");
      end
   endgenerate

   ipt_sel_e           sel;
   proc_vec_t          ipi_set, ipi_clr, tmr_clr, ipi_vec, tmr_vec;
   logic               bad_wr, ipi_dup, tmr_dup;
   logic [DATA_W-1:0]  rd_next;

   assign sel = ipt_sel_e'(req_sel);

   ipt_wr_decode #(.DATA_W(DATA_W)) i_dec (
      .wr_en   (req_valid && req_write),
      .sel     (sel),
      .wdata   (req_wdata),
      .ipi_set (ipi_set),
      .ipi_clr (ipi_clr),
      .tmr_clr (tmr_clr),
      .bad_wr  (bad_wr)
   );

   ipt_pend_vec #(.NPROC(NPROC), .CLEAR_WINS(1'b1)) i_ipi (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ipi_set),
      .clr_i  (ipi_clr),
      .pend_o (ipi_vec),
      .dup_o  (ipi_dup)
   );

   ipt_pend_vec #(.NPROC(NPROC), .CLEAR_WINS(1'b0)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({MAX_PROC{tick}}),
      .clr_i  (tmr_clr),
      .pend_o (tmr_vec),
      .dup_o  (tmr_dup)
   );

   ipt_rd_mux #(.DATA_W(DATA_W)) i_rd (
      .sel    (sel),
      .ipi    (ipi_vec),
      .tmr    (tmr_vec),
      .cpu_id (req_cpu),
      .data   (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         err_pulse  <= 1'b0;
         warn_pulse <= 1'b0;
      end else begin
         rd_valid   <= req_valid && !req_write;
         if (req_valid && !req_write) rd_data <= rd_next;
         err_pulse  <= bad_wr;
         warn_pulse <= ipi_dup;
      end
   end

   assign ipi_irq = ipi_vec[NPROC-1:0];
   assign tmr_irq = tmr_vec[NPROC-1:0];

   logic unused_ok;
   assign unused_ok = tmr_dup;

   AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write)); // R9
   AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(req_valid && req_write)); // R7
   AST_WARN_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      warn_pulse |-> $past(req_valid && req_write && req_sel != 2'd1 && req_sel != 2'd2)); // R8
endmodule

// File: tb/test_ipt_unit.sv
module test_ipt_unit;
   localparam int NP = 3;
   localparam int DW = 32;
   localparam logic [3:0] PM = 4'h7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [1:0]    req_sel = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_cpu = '0;
   logic          tick = 1'b0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [NP-1:0] ipi_irq, tmr_irq;
   logic          err_pulse, warn_pulse;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ipt_unit #(.NPROC(NP), .DATA_W(DW)) i_ipt_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .req_wdata(req_wdata), .req_cpu(req_cpu), .tick(tick),
      .rd_valid(rd_valid), .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
      .err_pulse(err_pulse), .warn_pulse(warn_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_sel = s; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] s, input logic [1:0] cpu);
      req_valid = 1'b1; req_write = 1'b0; req_sel = s; req_cpu = cpu;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_tick(input logic [31:0] ctrl_d, input logic with_wr);
      tick = 1'b1;
      if (with_wr) begin
         req_valid = 1'b1; req_write = 1'b1; req_sel = 2'd0; req_wdata = ctrl_d;
      end
      @(negedge clk);
      tick = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ipi", 32'(ipi_irq), 0);
      chk("R1 tmr", 32'(tmr_irq), 0);
      chk("R1 pulses", {29'd0, rd_valid, err_pulse, warn_pulse}, 0);

      // R2 request via control register
      wr(2'd0, 32'h1 << 12);
      chk("R2 request cpu0", 32'(ipi_irq), 32'h1);
      chk("R2 no err", 32'(err_pulse), 0);
      // R3 clear via control register
      wr(2'd0, 32'h1 << 8);
      chk("R3 clear cpu0", 32'(ipi_irq), 0);
      // R3 clearing non-pending is a no-op
      wr(2'd0, 32'h2 << 8);
      chk("R3 clear idle", 32'(ipi_irq), 0);
      chk("R3 clear idle warn", 32'(warn_pulse), 0);

      // R5 tick sets all present timer bits
      do_tick(0, 1'b0);
      chk("R5 tick", 32'(tmr_irq), 32'h7);
      // R3 timer clear of cpu1
      wr(2'd0, 32'h2 << 4);
      chk("R3 tmr clear", 32'(tmr_irq), 32'h5);
      // R5 tick together with clear of cpu0: tick wins
      do_tick(32'h1 << 4, 1'b1);
      chk("R5 tick wins", 32'(tmr_irq), 32'h7);

      // R6 absent processor
      wr(2'd0, 32'h8 << 12);
      chk("R6 absent ipi", 32'(ipi_irq), 0);
      chk("R6 no err", 32'(err_pulse), 0);

      // R7 ignored flag alone
      wr(2'd0, 32'h1 << 28);
      chk("R7 flag no err", 32'(err_pulse), 0);
      chk("R7 flag tmr kept", 32'(tmr_irq), 32'h7);
      // R7 empty write / only unrelated bits
      wr(2'd0, 32'h0);
      chk("R7 empty err", 32'(err_pulse), 1);
      @(negedge clk);
      chk("R7 err one cycle", 32'(err_pulse), 0);
      wr(2'd0, 32'h3);
      chk("R7 low bits err", 32'(err_pulse), 1);
      chk("R7 state kept", {24'd0, 1'b0, tmr_irq, 1'b0, ipi_irq}, {24'd0, 8'h70});

      // R9 control read
      wr(2'd0, 32'h4 << 12);
      rd(2'd0, 2'd2);
      chk("R9 rd_valid", 32'(rd_valid), 1);
      chk("R9 ctrl read", rd_data, (32'h4 << 8) | (32'h7 << 4) | 32'h2);
      @(negedge clk);
      chk("R9 rd_valid drop", 32'(rd_valid), 0);

      // R10 dedicated registers
      rd(2'd1, 2'd0);
      chk("R10 ipi vec", rd_data, 32'h4);
      rd(2'd2, 2'd0);
      chk("R10 tmr vec", rd_data, 32'h7);
      wr(2'd2, 32'h5);
      chk("R10 tmr clear", 32'(tmr_irq), 32'h2);
      wr(2'd1, 32'h4);
      chk("R10 ipi clear", 32'(ipi_irq), 0);
      rd(2'd3, 2'd1);
      chk("R10 req reg reads 0", rd_data, 0);

      // R11 request register
      wr(2'd3, 32'h3);
      chk("R11 post", 32'(ipi_irq), 32'h3);
      wr(2'd3, 32'h2);
      chk("R11 dup warn", 32'(warn_pulse), 1);
      chk("R11 dup state", 32'(ipi_irq), 32'h3);

      // R12 dedicated zero write
      wr(2'd1, 32'hF0);
      chk("R12 zero clear err", 32'(err_pulse), 1);
      chk("R12 state kept", 32'(ipi_irq), 32'h3);
      wr(2'd3, 32'h0);
      chk("R12 zero req err", 32'(err_pulse), 1);

      // Sweep: start state x request x clear (R2 R3 R4 R6 R7 R8)
      for (int s = 0; s < 16; s++) begin
         for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
               logic [3:0] st, ex;
               wr(2'd1, 32'hF);
               if (s != 0) wr(2'd3, 32'(s));
               st = 4'(s) & PM;
               ex = ((st | (4'(r) & PM)) & ~4'(c)) & PM;
               wr(2'd0, (32'(r) << 12) | (32'(c) << 8));
               chk("R4 sweep ipi", 32'(ipi_irq), 32'(ex));
               chk("R7 sweep err", 32'(err_pulse), 32'((r == 0) && (c == 0)));
               chk("R8 sweep warn", 32'(warn_pulse), 32'(((4'(r) & PM) & st) != 0));
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule